// File: doc/BRIEF.md
# Command Stream Method Dispatcher

This block consumes a stream of 32-bit command words, one per cycle when `cmd_valid` is high. It turns them into register-write transactions for four engines: 2D, 3D, compute and DMA copy. A word that arrives while no header is open is a header. The header names a base method, a subchannel, an argument count and a submission mode. The argument words that follow it become one write each, and the mode decides how the method address steps from one argument to the next. The inline mode carries its value inside the header itself and is followed by no argument words.

Each subchannel holds an engine identifier in a binding table. A write to method 0 loads that table and is not forwarded. Any other method below 0x40 belongs to the stream itself and is discarded. Every remaining write goes to the engine whose identifier is bound to the subchannel. The engine sees a one-cycle strobe with the method and data, and the 3D port also gets the count of arguments still to come in the header. An unknown mode, or a write on a subchannel whose binding matches no engine, sets a sticky error flag.

Top module: `mthd_dispatch`

## Requirements
- R1: After reset, no engine strobe is asserted, `decode_err` is 0 and every subchannel is unbound. The header layout is: method in bits 12:0, subchannel in bits 15:13, argument count in bits 28:16 and mode in bits 31:29.
- R2: Mode codes 0 and 1 (stepping) write argument i to method base+i.
- R3: Mode codes 2 and 3 (fixed) write every argument to the base method.
- R4: Mode code 5 (step-once) writes the first argument to the base method and every later argument to base+1.
- R5: Mode code 4 (inline) consumes no argument words. It produces one write whose value is header bits 28:16, zero-extended, and whose remaining count is 0. The next word is decoded as a header.
- R6: Each write carries a remaining count equal to the argument count minus the argument index minus 1, presented on `eng3d_remain` with the 3D strobe.
- R7: A write to method 0 stores its 32-bit value as the engine identifier of its subchannel. It raises no engine strobe, and it takes effect for the very next word.
- R8: A write to any method from 1 to 0x3F is dropped with no strobe and no error. Method 0x40 is forwarded.
- R9: Forwarded writes appear one cycle after their word, on exactly one strobe. The strobe is chosen by the bound identifier: 0x21 selects 2D, 0x31 selects 3D, 0x41 selects compute and 0x51 selects DMA.
- R10: A header with mode code 6 or 7 sets the sticky `decode_err` flag and emits nothing. The next word is decoded as a header, and the flag stays set until reset.
- R11: A forwarded-class write on a subchannel that is unbound, or bound to an identifier that matches no engine, raises no strobe and sets `decode_err`.
- R12: A header in a mode other than inline with an argument count of 0 emits no write. The next word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command word is present this cycle |
| cmd_word | input | 32 | Command word (header or argument) |
| eng2d_wr | output | 1 | Write strobe to the 2D engine |
| eng3d_wr | output | 1 | Write strobe to the 3D engine |
| engcmp_wr | output | 1 | Write strobe to the compute engine |
| engdma_wr | output | 1 | Write strobe to the DMA copy engine |
| wr_method | output | 13 | Method address of the current write |
| wr_data | output | 32 | Data value of the current write |
| eng3d_remain | output | 13 | Arguments still to come in the header, for the 3D engine |
| decode_err | output | 1 | Sticky decode error flag |

## Verification
The assertions watch, on every cycle, that at most one strobe fires and that a strobe follows exactly those transactions the router accepts. They also check that bind and low-method writes never reach an engine, that an unknown mode raises the error flag, and that the flag never clears without reset. The address stepping of each mode, the remaining counts, the inline value and the routing through rebinding can only be shown by the bench's scenarios. Those scenarios compare the complete write log of each header sequence against values built from the header layout.

// File: rtl/mthd_pkg.sv
package mthd_pkg;

  localparam int METH_W = 13;
  localparam int SUB_W  = 3;
  localparam int CNT_W  = 13;
  localparam int MODE_W = 3;
  localparam int WORD_W = 32;
  localparam int NUM_ENG = 4;
  localparam int ENG_W  = $clog2(NUM_ENG);

  // mode codes
  localparam logic [MODE_W-1:0] MD_STEP_A  = 3'd0;
  localparam logic [MODE_W-1:0] MD_STEP_B  = 3'd1;
  localparam logic [MODE_W-1:0] MD_FIXED_A = 3'd2;
  localparam logic [MODE_W-1:0] MD_FIXED_B = 3'd3;
  localparam logic [MODE_W-1:0] MD_INLINE  = 3'd4;
  localparam logic [MODE_W-1:0] MD_ONCE    = 3'd5;

  // engine slots
  localparam logic [ENG_W-1:0] SLOT_2D  = 2'd0;
  localparam logic [ENG_W-1:0] SLOT_3D  = 2'd1;
  localparam logic [ENG_W-1:0] SLOT_CMP = 2'd2;
  localparam logic [ENG_W-1:0] SLOT_DMA = 2'd3;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [CNT_W-1:0]  count;
    logic [SUB_W-1:0]  subch;
    logic [METH_W-1:0] method;
  } hdr_t;

  typedef struct packed {
    logic              vld;
    logic [METH_W-1:0] method;
    logic [SUB_W-1:0]  subch;
    logic [WORD_W-1:0] value;
    logic [CNT_W-1:0]  remain;
  } txn_t;

  // true for the modes that are followed by argument words
  function automatic logic mode_has_args(input logic [MODE_W-1:0] m);
    return (m == MD_STEP_A) || (m == MD_STEP_B) ||
           (m == MD_FIXED_A) || (m == MD_FIXED_B) || (m == MD_ONCE);
  endfunction

  // method address used for argument number idx
  function automatic logic [METH_W-1:0] step_method(
      input logic [MODE_W-1:0] m,
      input logic [METH_W-1:0] base,
      input logic [CNT_W-1:0]  idx);
    logic [METH_W-1:0] r;
    case (m)
      MD_STEP_A, MD_STEP_B: r = base + idx;
      MD_ONCE:              r = (idx == '0) ? base : base + 13'd1;
      default:              r = base;
    endcase
    return r;
  endfunction

  // arguments still to follow after argument idx
  function automatic logic [CNT_W-1:0] remain_of(
      input logic [CNT_W-1:0] cnt,
      input logic [CNT_W-1:0] idx);
    return cnt - idx - 13'd1;
  endfunction

endpackage

// File: rtl/mthd_hdr_parser.sv
module mthd_hdr_parser
  import mthd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output txn_t              txn,
  output logic              busy,
  output logic              evt_err_mode
);

  hdr_t              hdr;
  logic              busy_q, busy_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SUB_W-1:0]  sub_q, sub_n;
  logic [METH_W-1:0] base_q, base_n;
  logic [CNT_W-1:0]  idx_q, idx_n;

  assign hdr  = hdr_t'(word_data);
  assign busy = busy_q;

  always_comb begin
    txn          = '0;
    evt_err_mode = 1'b0;
    busy_n = busy_q;
    mode_n = mode_q;
    cnt_n  = cnt_q;
    sub_n  = sub_q;
    base_n = base_q;
    idx_n  = idx_q;
    if (word_valid) begin
      if (!busy_q) begin
        if (hdr.mode == MD_INLINE) begin
          txn.vld    = 1'b1;
          txn.method = hdr.method;
          txn.subch  = hdr.subch;
          txn.value  = {{(WORD_W-CNT_W){1'b0}}, hdr.count};
          txn.remain = '0;
        end else if (mode_has_args(hdr.mode)) begin
          if (hdr.count != '0) begin
            busy_n = 1'b1;
            mode_n = hdr.mode;
            cnt_n  = hdr.count;
            sub_n  = hdr.subch;
            base_n = hdr.method;
            idx_n  = '0;
          end
        end else begin
          evt_err_mode = 1'b1;
        end
      end else begin
        txn.vld    = 1'b1;
        txn.method = step_method(mode_q, base_q, idx_q);
        txn.subch  = sub_q;
        txn.value  = word_data;
        txn.remain = remain_of(cnt_q, idx_q);
        idx_n      = idx_q + 13'd1;
        if (idx_q == cnt_q - 13'd1) busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= '0;
      cnt_q  <= '0;
      sub_q  <= '0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      sub_q  <= sub_n;
      base_q <= base_n;
      idx_q  <= idx_n;
    end
  end

endmodule

// File: rtl/mthd_bind_table.sv
module mthd_bind_table
  import mthd_pkg::*;
#(
  parameter int NUM_SUB = 8,
  parameter logic [NUM_ENG-1:0][WORD_W-1:0] ENG_IDS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SUB_W-1:0]  wr_sub,
  input  logic [WORD_W-1:0] wr_id,
  input  logic [SUB_W-1:0]  rd_sub,
  output logic              hit,
  output logic [ENG_W-1:0]  eng_sel
);

  logic [NUM_SUB-1:0] bound_q;
  logic [WORD_W-1:0]  id_q [NUM_SUB];
  logic               rd_bound;
  logic [WORD_W-1:0]  rd_id;
  logic [NUM_ENG-1:0] match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_q <= '0;
      for (int s = 0; s < NUM_SUB; s++) id_q[s] <= '0;
    end else if (wr_en) begin
      bound_q[wr_sub] <= 1'b1;
      id_q[wr_sub]    <= wr_id;
    end
  end

  assign rd_bound = bound_q[rd_sub];
  assign rd_id    = id_q[rd_sub];

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_match
    assign match[e] = rd_bound && (rd_id == ENG_IDS[e]);
  end

  assign hit = |match;

  always_comb begin
    eng_sel = '0;
    for (int e = NUM_ENG - 1; e >= 0; e--) begin
      if (match[e]) eng_sel = ENG_W'(e);
    end
  end

endmodule

// File: rtl/mthd_router.sv
module mthd_router
  import mthd_pkg::*;
#(
  parameter int NUM_SUB = 8,
  parameter logic [NUM_ENG-1:0][WORD_W-1:0] ENG_IDS = '0,
  parameter logic [METH_W-1:0] BIND_METHOD = '0,
  parameter logic [METH_W-1:0] LOW_LIMIT = 13'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  txn_t               txn,
  output logic [NUM_ENG-1:0] wr_valid,
  output logic [METH_W-1:0]  wr_method,
  output logic [WORD_W-1:0]  wr_data,
  output logic [CNT_W-1:0]   wr_remain,
  output logic               evt_bind,
  output logic               evt_drop,
  output logic               evt_fwd,
  output logic               evt_err_eng
);

  logic             is_eng;
  logic             hit;
  logic [ENG_W-1:0] eng_sel;

  assign evt_bind = txn.vld && (txn.method == BIND_METHOD);
  assign evt_drop = txn.vld && !evt_bind && (txn.method < LOW_LIMIT);
  assign is_eng   = txn.vld && !evt_bind && !evt_drop;

  mthd_bind_table #(
    .NUM_SUB (NUM_SUB),
    .ENG_IDS (ENG_IDS)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (evt_bind),
    .wr_sub  (txn.subch),
    .wr_id   (txn.value),
    .rd_sub  (txn.subch),
    .hit     (hit),
    .eng_sel (eng_sel)
  );

  assign evt_fwd     = is_eng && hit;
  assign evt_err_eng = is_eng && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid  <= '0;
      wr_method <= '0;
      wr_data   <= '0;
      wr_remain <= '0;
    end else begin
      wr_valid <= evt_fwd ? (NUM_ENG'(1) << eng_sel) : '0;
      if (evt_fwd) begin
        wr_method <= txn.method;
        wr_data   <= txn.value;
        wr_remain <= txn.remain;
      end
    end
  end

endmodule

// File: rtl/mthd_dispatch.sv
module mthd_dispatch
  import mthd_pkg::*;
#(
  parameter logic [31:0] ID_2D  = 32'h0000_0021,
  parameter logic [31:0] ID_3D  = 32'h0000_0031,
  parameter logic [31:0] ID_CMP = 32'h0000_0041,
  parameter logic [31:0] ID_DMA = 32'h0000_0051,
  parameter logic [12:0] BIND_METHOD = 13'h000,
  parameter logic [12:0] LOW_LIMIT   = 13'h040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  output logic        eng2d_wr,
  output logic        eng3d_wr,
  output logic        engcmp_wr,
  output logic        engdma_wr,
  output logic [12:0] wr_method,
  output logic [31:0] wr_data,
  output logic [12:0] eng3d_remain,
  output logic        decode_err
);

  localparam int NUM_SUB = 2 ** SUB_W;
  localparam logic [NUM_ENG-1:0][WORD_W-1:0] ENG_IDS = {ID_DMA, ID_CMP, ID_3D, ID_2D};

  txn_t               txn;
  logic               busy;
  logic               evt_err_mode;
  logic               evt_bind, evt_drop, evt_fwd, evt_err_eng;
  logic [NUM_ENG-1:0] wr_valid;
  logic               err_q;

  mthd_hdr_parser u_parser (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (cmd_valid),
    .word_data    (cmd_word),
    .txn          (txn),
    .busy         (busy),
    .evt_err_mode (evt_err_mode)
  );

  mthd_router #(
    .NUM_SUB     (NUM_SUB),
    .ENG_IDS     (ENG_IDS),
    .BIND_METHOD (BIND_METHOD),
    .LOW_LIMIT   (LOW_LIMIT)
  ) u_router (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn         (txn),
    .wr_valid    (wr_valid),
    .wr_method   (wr_method),
    .wr_data     (wr_data),
    .wr_remain   (eng3d_remain),
    .evt_bind    (evt_bind),
    .evt_drop    (evt_drop),
    .evt_fwd     (evt_fwd),
    .evt_err_eng (evt_err_eng)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (evt_err_mode || evt_err_eng) err_q <= 1'b1;
  end

  assign eng2d_wr   = wr_valid[SLOT_2D];
  assign eng3d_wr   = wr_valid[SLOT_3D];
  assign engcmp_wr  = wr_valid[SLOT_CMP];
  assign engdma_wr  = wr_valid[SLOT_DMA];
  assign decode_err = err_q;

endmodule

// File: rtl/mthd_dispatch_chk.sv
module mthd_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [31:0] cmd_word,
  input logic        busy,
  input logic [3:0]  wr_valid,
  input logic        decode_err,
  input logic        evt_fwd,
  input logic        evt_bind,
  input logic        evt_drop,
  input logic        evt_err_eng
);

  // R9: never more than one engine strobe
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_valid));

  // R9: an accepted transaction yields one strobe on the next cycle
  p_fwd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fwd |=> ($countones(wr_valid) == 1));

  // R9: no strobe without an accepted transaction
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_fwd |=> (wr_valid == 4'b0000));

  // R7: a bind write reaches no engine
  p_bind_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bind |=> (wr_valid == 4'b0000));

  // R8: a low-method write reaches no engine
  p_low_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> (wr_valid == 4'b0000));

  // R10: an unknown mode header raises the flag and leaves no header open
  p_bad_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_word[31:29] > 3'd5)) |=> (decode_err && !busy));

  // R11: an unroutable write raises the flag
  p_unbound_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err_eng |=> decode_err);

  // R10: the flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |=> decode_err);

  // R5: an inline header opens no argument phase
  p_inline_no_args_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_word[31:29] == 3'd4)) |=> !busy);

endmodule

bind mthd_dispatch mthd_dispatch_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_word    (cmd_word),
  .busy        (busy),
  .wr_valid    (wr_valid),
  .decode_err  (decode_err),
  .evt_fwd     (evt_fwd),
  .evt_bind    (evt_bind),
  .evt_drop    (evt_drop),
  .evt_err_eng (evt_err_eng)
);

// File: tb/mthd_dispatch_bench.sv
module mthd_dispatch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        eng2d_wr, eng3d_wr, engcmp_wr, engdma_wr;
  logic [12:0] wr_method;
  logic [31:0] wr_data;
  logic [12:0] eng3d_remain;
  logic        decode_err;

  int checks = 0;
  int errors = 0;

  // engine codes used in the logs: 0=2D 1=3D 2=compute 3=DMA
  int log_n = 0;
  int log_eng [64];
  int log_meth [64];
  int log_data [64];
  int log_rem [64];
  int exp_n = 0;
  int exp_eng [64];
  int exp_meth [64];
  int exp_data [64];
  int exp_rem [64];

  always #4 clk = ~clk;

  mthd_dispatch u_mthd_dispatch (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .eng2d_wr     (eng2d_wr),
    .eng3d_wr     (eng3d_wr),
    .engcmp_wr    (engcmp_wr),
    .engdma_wr    (engdma_wr),
    .wr_method    (wr_method),
    .wr_data      (wr_data),
    .eng3d_remain (eng3d_remain),
    .decode_err   (decode_err)
  );

  task automatic add_log(input int e);
    if (log_n < 64) begin
      log_eng[log_n]  = e;
      log_meth[log_n] = int'(wr_method);
      log_data[log_n] = int'(wr_data);
      log_rem[log_n]  = int'(eng3d_remain);
    end
    log_n++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (eng2d_wr)  add_log(0);
      if (eng3d_wr)  add_log(1);
      if (engcmp_wr) add_log(2);
      if (engdma_wr) add_log(3);
    end
  end

  function automatic logic [31:0] hdr(input int mode, input int cnt, input int sub, input int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic expect_w(input int e, input int m, input int d, input int r);
    exp_eng[exp_n]  = e;
    exp_meth[exp_n] = m;
    exp_data[exp_n] = d;
    exp_rem[exp_n]  = r;
    exp_n++;
  endtask

  task automatic check_log(input string req);
    check(log_n == exp_n, req, "write count", log_n, exp_n);
    if (log_n == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        check(log_eng[i] == exp_eng[i], req, "engine", log_eng[i], exp_eng[i]);
        check(log_meth[i] == exp_meth[i], req, "method", log_meth[i], exp_meth[i]);
        check(log_data[i] == exp_data[i], req, "data", log_data[i], exp_data[i]);
        if (exp_eng[i] == 1)
          check(log_rem[i] == exp_rem[i], req, "remaining", log_rem[i], exp_rem[i]);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bind_all();
    put(hdr(4, 32'h31, 0, 0));          // subch0 -> 3D, inline
    put(hdr(4, 32'h21, 1, 0));          // subch1 -> 2D, inline
    put(hdr(1, 1, 2, 0)); put(32'h41);  // subch2 -> compute
    put(hdr(3, 1, 3, 0)); put(32'h51);  // subch3 -> DMA
    idle(3);
  endtask

  task automatic t_reset();
    check({eng2d_wr, eng3d_wr, engcmp_wr, engdma_wr} == 4'b0, "R1", "strobes after reset",
          int'({eng2d_wr, eng3d_wr, engcmp_wr, engdma_wr}), 0);
    check(decode_err == 1'b0, "R1", "error after reset", int'(decode_err), 0);
  endtask

  task automatic t_bind();
    clear_logs();
    bind_all();
    check_log("R7");
    check(decode_err == 1'b0, "R7", "error after binds", int'(decode_err), 0);
  endtask

  task automatic t_step();
    clear_logs();
    put(hdr(1, 3, 0, 32'h100)); put(32'hA0); put(32'hA1); put(32'hA2);
    put(hdr(0, 2, 1, 32'h200)); put(32'hB0); put(32'hB1);
    idle(3);
    expect_w(1, 32'h100, 32'hA0, 2);
    expect_w(1, 32'h101, 32'hA1, 1);
    expect_w(1, 32'h102, 32'hA2, 0);
    expect_w(0, 32'h200, 32'hB0, 0);
    expect_w(0, 32'h201, 32'hB1, 0);
    check_log("R2 R6 R9");
  endtask

  task automatic t_fixed();
    clear_logs();
    put(hdr(3, 2, 2, 32'h300)); put(32'hC0); put(32'hC1);
    put(hdr(2, 2, 3, 32'h310)); put(32'hD0); put(32'hD1);
    put(hdr(2, 3, 0, 32'h320)); put(32'hE0); put(32'hE1); put(32'hE2);
    idle(3);
    expect_w(2, 32'h300, 32'hC0, 0);
    expect_w(2, 32'h300, 32'hC1, 0);
    expect_w(3, 32'h310, 32'hD0, 0);
    expect_w(3, 32'h310, 32'hD1, 0);
    expect_w(1, 32'h320, 32'hE0, 2);
    expect_w(1, 32'h320, 32'hE1, 1);
    expect_w(1, 32'h320, 32'hE2, 0);
    check_log("R3 R6");
  endtask

  task automatic t_once();
    clear_logs();
    put(hdr(5, 4, 0, 32'h400));
    put(32'h11); put(32'h12); put(32'h13); put(32'h14);
    put(hdr(5, 1, 2, 32'h410)); put(32'h15);
    idle(3);
    expect_w(1, 32'h400, 32'h11, 3);
    expect_w(1, 32'h401, 32'h12, 2);
    expect_w(1, 32'h401, 32'h13, 1);
    expect_w(1, 32'h401, 32'h14, 0);
    expect_w(2, 32'h410, 32'h15, 0);
    check_log("R4");
  endtask

  task automatic t_inline();
    clear_logs();
    put(hdr(4, 32'h1ABC, 0, 32'h500));
    put(hdr(4, 32'h0007, 3, 32'h501));
    put(hdr(1, 1, 0, 32'h502)); put(32'hFFFF_0001);
    idle(3);
    expect_w(1, 32'h500, 32'h1ABC, 0);
    expect_w(3, 32'h501, 32'h0007, 0);
    expect_w(1, 32'h502, 32'hFFFF_0001, 0);
    check_log("R5");
  endtask

  task automatic t_low();
    clear_logs();
    put(hdr(1, 3, 0, 32'h03E)); put(32'h61); put(32'h62); put(32'h63);
    put(hdr(4, 5, 1, 32'h001));
    idle(3);
    expect_w(1, 32'h040, 32'h63, 0);
    check_log("R8");
    check(decode_err == 1'b0, "R8", "error after low methods", int'(decode_err), 0);
  endtask

  task automatic t_zero_count();
    clear_logs();
    put(hdr(1, 0, 0, 32'h600));
    put(hdr(5, 0, 0, 32'h610));
    put(hdr(4, 9, 0, 32'h620));
    idle(3);
    expect_w(1, 32'h620, 9, 0);
    check_log("R12");
  endtask

  task automatic t_rebind();
    clear_logs();
    put(hdr(1, 2, 0, 32'h000)); put(32'h51); put(32'h99);  // rebind then method 1 dropped
    put(hdr(4, 3, 0, 32'h700));
    idle(3);
    expect_w(3, 32'h700, 3, 0);
    check_log("R7 R9");
  endtask

  task automatic t_unbound();
    clear_logs();
    check(decode_err == 1'b0, "R11", "error before", int'(decode_err), 0);
    put(hdr(4, 1, 5, 32'h800));                       // subch5 unbound
    idle(3);
    check_log("R11");
    check(decode_err == 1'b1, "R11", "error unbound", int'(decode_err), 1);
    do_reset();
    check(decode_err == 1'b0, "R1", "error cleared by reset", int'(decode_err), 0);
    clear_logs();
    put(hdr(4, 32'h77, 4, 0));                        // subch4 bound to unknown id
    put(hdr(4, 2, 4, 32'h810));
    idle(3);
    check_log("R11");
    check(decode_err == 1'b1, "R11", "error unknown id", int'(decode_err), 1);
    do_reset();
  endtask

  task automatic t_bad_mode();
    clear_logs();
    bind_all();
    clear_logs();
    put(hdr(6, 2, 0, 32'h900));
    put(hdr(4, 4, 0, 32'h901));   // decoded as a header
    idle(3);
    expect_w(1, 32'h901, 4, 0);
    check_log("R10");
    check(decode_err == 1'b1, "R10", "error mode 6", int'(decode_err), 1);
    clear_logs();
    put(hdr(7, 0, 1, 32'h902));
    put(hdr(4, 6, 1, 32'h903));
    idle(3);
    expect_w(0, 32'h903, 6, 0);
    check_log("R10");
    check(decode_err == 1'b1, "R10", "error stays set", int'(decode_err), 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_bind();
    t_step();
    t_fixed();
    t_once();
    t_inline();
    t_low();
    t_zero_count();
    t_rebind();
    t_unbound();
    t_bad_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule